// File: doc/BRIEF.md
# GPIO pin ownership manager

This block decides, pin by pin, which of four GPIO controllers drives each chip pad. It also decides which of those controllers may observe the pad's input level. Every pin has a configuration word with three fields:

- a 2-bit owner code;
- a 4-bit mask that hides the pin's input from chosen controllers;
- a lock bit that software can set but never clear.

A small register bus with byte enables reads and writes these words.

The pad side is purely combinational. The owner's output and output-enable go straight to the pad. Unselected controllers are ignored. Each controller receives the pad input level, or a constant 0 when its mask bit is set. Pins are grouped into ports, and the port count and pin count per port are parameters, so a small instance can be checked exhaustively.

Top module: `gpio_pin_owner_mgr`

## Requirements
- R1: After reset every configuration word reads 0: owner is controller 0, no controller is masked, the word is unlocked, and the read data output is 0.
- R2: The word of pin N in port P sits at byte address P*128 + N*4, and address bits [1:0] are ignored. The read data for the address presented in one cycle appears after the next rising clock edge, and shows the word as it was before any write taken at that edge.
- R3: Word bits [1:0] hold the owner code: 0, 1, 2 and 3 select controllers 0, 1, 2 and 3. Bits [11:8] hold the mask, with bit 8+c belonging to controller c. Bit 31 is the lock.
- R4: Byte enable 0 gates the owner field, byte enable 1 gates the mask field and byte enable 3 gates the lock bit. Byte enable 2 changes nothing.
- R5: Bits [7:2] and [30:12] always read 0, whatever was written to them.
- R6: An address whose port field (bits above 6) is at least the port count, or whose pin field (bits [6:2]) is at least the pins per port, reads 0. A write to such an address changes no configuration word.
- R7: A write that sets the lock also updates the other enabled fields in the same write. After that, every write to the locked word is ignored.
- R8: Each pad output and pad output-enable equal, in the same cycle, the output and output-enable of the controller named by that pin's owner field. Other controllers have no effect.
- R9: Controller c sees, in the same cycle, the pad input of pin p, or 0 when mask bit c of pin p is set. This holds whether or not c owns the pin.
- R10: Software cannot clear the lock. Only the reset returns it to 0, after which the word is writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the configuration word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Registered read data |
| ctrl_out | input | 4 x N_PINS | Output level requested by each controller per pin |
| ctrl_oe | input | 4 x N_PINS | Output enable requested by each controller per pin |
| ctrl_in | output | 4 x N_PINS | Input level delivered to each controller per pin |
| pad_in | input | N_PINS | Level seen at each pad |
| pad_out | output | N_PINS | Level driven to each pad |
| pad_oe | output | N_PINS | Output enable driven to each pad |

## Verification
Pad routing and input masking are combinational. Their results are due in the same cycle as the controller or pad inputs. They are due in the cycle after the rising edge that takes a configuration write. Read data is due one rising edge after the address is presented, and it reflects the configuration held before that edge. The bench drives every input at the falling edge and updates its behavioural model at the rising edge. It compares all outputs 1 ns after each falling edge, so each result is sampled only once every register on its path has been clocked.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int N_CTRL       = 4;
  localparam int OWNER_W      = 2;
  localparam int WORD_W       = 32;
  localparam int BE_W         = WORD_W / 8;
  localparam int OWNER_LSB    = 0;
  localparam int HIDE_LSB     = 8;
  localparam int LOCK_POS     = 31;
  localparam int PORT_SPAN_LG = 7;   // 128 bytes per port
  localparam int PIN_FIELD_W  = PORT_SPAN_LG - 2;

  typedef logic [OWNER_W-1:0] owner_t;

  typedef struct packed {
    logic              locked;
    logic [N_CTRL-1:0] hide;
    owner_t            owner;
  } pin_cfg_t;

  // Place the stored fields at their bus bit positions.
  function automatic logic [WORD_W-1:0] cfg_to_word(pin_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OWNER_LSB +: OWNER_W] = c.owner;
    w[HIDE_LSB +: N_CTRL]   = c.hide;
    w[LOCK_POS]             = c.locked;
    return w;
  endfunction

  localparam logic [WORD_W-1:0] IMPL_MASK = cfg_to_word('1);

  // Merge a write into a word; the lock bit can only be raised.
  function automatic pin_cfg_t apply_write(pin_cfg_t cur, logic [WORD_W-1:0] wd,
                                           logic [BE_W-1:0] be);
    pin_cfg_t n;
    n = cur;
    if (be[OWNER_LSB / 8]) n.owner  = wd[OWNER_LSB +: OWNER_W];
    if (be[HIDE_LSB / 8])  n.hide   = wd[HIDE_LSB +: N_CTRL];
    if (be[LOCK_POS / 8])  n.locked = cur.locked | wd[LOCK_POS];
    return n;
  endfunction

  function automatic int pin_index(int port, int pin, int pins_per_port);
    return port * pins_per_port + pin;
  endfunction

  function automatic logic gate_input(logic level, logic hidden);
    return level & ~hidden;
  endfunction
endpackage

// File: rtl/gpm_addr_decode.sv
module gpm_addr_decode
  import gpm_pkg::*;
#(
  parameter int N_PORTS       = 16,
  parameter int PINS_PER_PORT = 32,
  parameter int WADDR_W       = 6,
  parameter int IDX_W         = 9
) (
  input  logic [WADDR_W-1:0] word_addr,
  output logic [IDX_W-1:0]   idx,
  output logic               hit
);
  localparam int PORT_W = WADDR_W - PIN_FIELD_W;

  logic [PORT_W-1:0]      port_f;
  logic [PIN_FIELD_W-1:0] pin_f;

  assign port_f = word_addr[WADDR_W-1:PIN_FIELD_W];
  assign pin_f  = word_addr[PIN_FIELD_W-1:0];

  always_comb begin
    hit = (int'(port_f) < N_PORTS) && (int'(pin_f) < PINS_PER_PORT);
    idx = hit ? IDX_W'(pin_index(int'(port_f), int'(pin_f), PINS_PER_PORT)) : '0;
  end
endmodule

// File: rtl/gpm_cfg_regs.sv
module gpm_cfg_regs
  import gpm_pkg::*;
#(
  parameter int N_PINS = 512,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output pin_cfg_t          cfg_vec [N_PINS],
  output logic [N_PINS-1:0] wr_en_vec,
  output logic [N_PINS-1:0] wr_blocked_vec,
  output logic [WORD_W-1:0] rdata
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_cfg_t cfg_q;

    assign wr_en_vec[i]      = wr_req && hit && (idx == IDX_W'(i));
    assign wr_blocked_vec[i] = wr_en_vec[i] && cfg_q.locked;
    assign cfg_vec[i]        = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (wr_en_vec[i] && !cfg_q.locked) cfg_q <= apply_write(cfg_q, wdata, be);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (hit) rdata <= cfg_to_word(cfg_vec[idx]);
    else          rdata <= '0;
  end
endmodule

// File: rtl/gpm_pad_route.sv
module gpm_pad_route
  import gpm_pkg::*;
#(
  parameter int N_PINS = 512
) (
  input  pin_cfg_t                       cfg_vec [N_PINS],
  input  logic [N_CTRL-1:0][N_PINS-1:0] ctrl_out,
  input  logic [N_CTRL-1:0][N_PINS-1:0] ctrl_oe,
  input  logic [N_PINS-1:0]             pad_in,
  output logic [N_PINS-1:0]             pad_out,
  output logic [N_PINS-1:0]             pad_oe,
  output logic [N_CTRL-1:0][N_PINS-1:0] ctrl_in
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pad_out[i] = ctrl_out[cfg_vec[i].owner][i];
    assign pad_oe[i]  = ctrl_oe[cfg_vec[i].owner][i];
    for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
      assign ctrl_in[c][i] = gate_input(pad_in[i], cfg_vec[i].hide[c]);
    end
  end
endmodule

// File: rtl/gpio_pin_owner_mgr.sv
module gpio_pin_owner_mgr
  import gpm_pkg::*;
#(
  parameter int N_PORTS       = 16,
  parameter int PINS_PER_PORT = 32,
  localparam int N_PINS       = N_PORTS * PINS_PER_PORT,
  localparam int PORT_W       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int ADDR_W       = PORT_W + PORT_SPAN_LG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  input  logic                          bus_we,
  input  logic [BE_W-1:0]               bus_be,
  output logic [WORD_W-1:0]             bus_rdata,
  input  logic [N_CTRL-1:0][N_PINS-1:0] ctrl_out,
  input  logic [N_CTRL-1:0][N_PINS-1:0] ctrl_oe,
  output logic [N_CTRL-1:0][N_PINS-1:0] ctrl_in,
  input  logic [N_PINS-1:0]             pad_in,
  output logic [N_PINS-1:0]             pad_out,
  output logic [N_PINS-1:0]             pad_oe
);
  localparam int IDX_W   = (N_PINS > 1) ? $clog2(N_PINS) : 1;
  localparam int WADDR_W = ADDR_W - 2;

  logic [IDX_W-1:0]  addr_idx;
  logic              addr_hit;
  logic [N_PINS-1:0] wr_en_vec;
  logic [N_PINS-1:0] wr_blocked_vec;
  pin_cfg_t          cfg_vec [N_PINS];
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];

  gpm_addr_decode #(
    .N_PORTS(N_PORTS), .PINS_PER_PORT(PINS_PER_PORT),
    .WADDR_W(WADDR_W), .IDX_W(IDX_W)
  ) u_decode (
    .word_addr(bus_addr[ADDR_W-1:2]),
    .idx      (addr_idx),
    .hit      (addr_hit)
  );

  gpm_cfg_regs #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_req        (bus_we),
    .hit           (addr_hit),
    .idx           (addr_idx),
    .wdata         (bus_wdata),
    .be            (bus_be),
    .cfg_vec       (cfg_vec),
    .wr_en_vec     (wr_en_vec),
    .wr_blocked_vec(wr_blocked_vec),
    .rdata         (bus_rdata)
  );

  gpm_pad_route #(.N_PINS(N_PINS)) u_route (
    .cfg_vec (cfg_vec),
    .ctrl_out(ctrl_out),
    .ctrl_oe (ctrl_oe),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .ctrl_in (ctrl_in)
  );
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
  import gpm_pkg::*;
#(
  parameter int N_PINS = 512
) (
  input logic                          clk,
  input logic                          rst_n,
  input pin_cfg_t                      cfg_vec [N_PINS],
  input logic [N_PINS-1:0]             wr_en_vec,
  input logic [N_PINS-1:0]             wr_blocked_vec,
  input logic                          addr_hit,
  input logic [WORD_W-1:0]             bus_rdata,
  input logic [N_PINS-1:0]             pad_in,
  input logic [N_CTRL-1:0][N_PINS-1:0] ctrl_in
);
  pin_cfg_t          prev_cfg [N_PINS];
  logic [N_PINS-1:0] lock_vec, prev_lock_vec, changed_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PINS; i++) prev_cfg[i] <= '0;
    end else begin
      for (int i = 0; i < N_PINS; i++) prev_cfg[i] <= cfg_vec[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N_PINS; i++) begin
      lock_vec[i]      = cfg_vec[i].locked;
      prev_lock_vec[i] = prev_cfg[i].locked;
      changed_vec[i]   = (cfg_vec[i] != prev_cfg[i]);
    end
  end

  p_lock_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((changed_vec & prev_lock_vec) == '0));

  p_blocked_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_blocked_vec) |=> ((changed_vec & $past(wr_blocked_vec)) == '0));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev_lock_vec & ~lock_vec) == '0));

  p_single_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_vec));

  p_miss_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (bus_rdata == '0));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL_MASK) == '0));

  for (genvar c = 0; c < N_CTRL; c++) begin : g_in
    p_input_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_in[c] & ~pad_in) == '0));
  end
endmodule

bind gpio_pin_owner_mgr gpm_checker #(.N_PINS(N_PINS)) u_gpm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_vec       (cfg_vec),
  .wr_en_vec     (wr_en_vec),
  .wr_blocked_vec(wr_blocked_vec),
  .addr_hit      (addr_hit),
  .bus_rdata     (bus_rdata),
  .pad_in        (pad_in),
  .ctrl_in       (ctrl_in)
);

// File: tb/tb_gpio_pin_owner_mgr.sv
module tb_gpio_pin_owner_mgr;
  localparam int NP = 2, PP = 8, NPIN = 16;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [7:0]        bus_addr = 0;
  logic [31:0]       bus_wdata = 0;
  logic              bus_we = 0;
  logic [3:0]        bus_be = 0;
  logic [31:0]       bus_rdata;
  logic [3:0][15:0]  ctrl_out = 0, ctrl_oe = 0, ctrl_in;
  logic [15:0]       pad_in = 0, pad_out, pad_oe;

  gpio_pin_owner_mgr #(.N_PORTS(NP), .PINS_PER_PORT(PP)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, live_cmp = 0, rand_io = 0;

  int m_owner [NPIN];
  int m_hide  [NPIN];
  int m_lock  [NPIN];
  logic [31:0] exp_rdata = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit a_ok(logic [7:0] a);
    return (int'(a) / 128 < NP) && ((int'(a) % 128) / 4 < PP);
  endfunction
  function automatic int a_idx(logic [7:0] a);
    return (int'(a) / 128) * PP + (int'(a) % 128) / 4;
  endfunction
  function automatic logic [31:0] m_word(int k);
    return 32'(m_owner[k]) + 32'(m_hide[k]) * 256 + (m_lock[k] != 0 ? 32'h8000_0000 : 32'h0);
  endfunction
  function automatic logic [7:0] pin_addr(int k);
    return 8'((k / PP) * 128 + (k % PP) * 4);
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPIN; k++) begin m_owner[k] = 0; m_hide[k] = 0; m_lock[k] = 0; end
      exp_rdata = 0;
    end else begin
      int k;
      k = a_idx(bus_addr);
      exp_rdata = a_ok(bus_addr) ? m_word(k) : 32'h0;
      if (bus_we && a_ok(bus_addr) && m_lock[k] == 0) begin
        if (bus_be[0]) m_owner[k] = int'(bus_wdata[1:0]);
        if (bus_be[1]) m_hide[k]  = int'(bus_wdata[11:8]);
        if (bus_be[3] && bus_wdata[31]) m_lock[k] = 1;
      end
    end
  end

  // Every-cycle comparison, 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && live_cmp) begin
      logic [15:0] e_out, e_oe;
      logic [3:0][15:0] e_in;
      for (int i = 0; i < NPIN; i++) begin
        e_out[i] = ctrl_out[m_owner[i]][i];
        e_oe[i]  = ctrl_oe[m_owner[i]][i];
        for (int c = 0; c < 4; c++) e_in[c][i] = m_hide[i][c] ? 1'b0 : pad_in[i];
      end
      chk(pad_out == e_out, "R8", "pad_out", 64'(pad_out), 64'(e_out));
      chk(pad_oe == e_oe, "R8", "pad_oe", 64'(pad_oe), 64'(e_oe));
      chk(ctrl_in == e_in, "R9", "ctrl_in", 64'(ctrl_in), 64'(e_in));
      chk(bus_rdata == exp_rdata, "R2", "rdata", 64'(bus_rdata), 64'(exp_rdata));
    end
  end

  always @(negedge clk) begin
    if (rand_io) begin
      ctrl_out = 64'({$urandom(), $urandom()});
      ctrl_oe  = 64'({$urandom(), $urandom()});
      pad_in   = 16'($urandom());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    #2;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    #2;
    chk(bus_rdata == 0, "R1", "rdata after reset", 64'(bus_rdata), 0);
    for (int k = 0; k < NPIN; k++) begin
      rd(pin_addr(k), v);
      chk(v == 0, "R1", "word after reset", 64'(v), 0);
    end
    live_cmp = 1;

    // R3: distinct owner and mask per pin
    for (int k = 0; k < NPIN; k++)
      wr(pin_addr(k), 32'(k % 4) | (32'((k * 5) % 16) << 8), 4'hF);
    for (int k = 0; k < NPIN; k++) begin
      rd(pin_addr(k), v);
      chk(v == (32'(k % 4) | (32'((k * 5) % 16) << 8)), "R3", "field readback", 64'(v),
          64'(32'(k % 4) | (32'((k * 5) % 16) << 8)));
    end

    // R8: only the owner (pin 3 -> controller 3) reaches the pad
    @(negedge clk);
    ctrl_out = 0; ctrl_oe = 0;
    ctrl_out[3][3] = 1; ctrl_oe[3][3] = 1;
    #1;
    chk(pad_out[3] && pad_oe[3], "R8", "owner drives pad", 64'({pad_out[3], pad_oe[3]}), 64'h3);
    ctrl_out[3][3] = 0; ctrl_oe[3][3] = 0;
    ctrl_out[0][3] = 1; ctrl_out[1][3] = 1; ctrl_out[2][3] = 1;
    ctrl_oe[0][3] = 1; ctrl_oe[1][3] = 1; ctrl_oe[2][3] = 1;
    #1;
    chk(!pad_out[3] && !pad_oe[3], "R8", "non-owners ignored", 64'({pad_out[3], pad_oe[3]}), 0);

    // R9: pin 1 mask 0101, pin 3 mask 1111 (hidden from its own owner)
    pad_in = 16'h000A;
    #1;
    chk({ctrl_in[3][1], ctrl_in[2][1], ctrl_in[1][1], ctrl_in[0][1]} == 4'b1010, "R9",
        "pin1 masking", 64'({ctrl_in[3][1], ctrl_in[2][1], ctrl_in[1][1], ctrl_in[0][1]}), 64'hA);
    chk({ctrl_in[3][3], ctrl_in[2][3], ctrl_in[1][3], ctrl_in[0][3]} == 4'b0000, "R9",
        "pin3 hidden from owner", 64'({ctrl_in[3][3], ctrl_in[2][3], ctrl_in[1][3], ctrl_in[0][3]}), 0);

    // R4 and R5 on pin 6
    wr(8'h18, 32'hFFFF_FFFF, 4'b0011);
    rd(8'h18, v);
    chk(v == 32'h0000_0F03, "R5", "unused bits zero", 64'(v), 64'h0F03);
    wr(8'h18, 32'h0, 4'b0100);
    rd(8'h18, v);
    chk(v == 32'h0000_0F03, "R4", "byte 2 no effect", 64'(v), 64'h0F03);
    wr(8'h18, 32'h0000_0100, 4'b0010);
    rd(8'h18, v);
    chk(v == 32'h0000_0103, "R4", "byte 1 only mask", 64'(v), 64'h0103);

    // R6: pin field beyond the pins per port
    wr(8'h20, 32'hFFFF_FFFF, 4'hF);
    rd(8'h20, v);
    chk(v == 0, "R6", "unmapped read", 64'(v), 0);
    rd(8'hA0, v);
    chk(v == 0, "R6", "unmapped read port1", 64'(v), 0);
    rd(8'h00, v);
    chk(v == 0, "R6", "no alias into pin 0", 64'(v), 0);

    // R7 lock on pin 5
    wr(8'h14, 32'h8000_0102, 4'hF);
    rd(8'h14, v);
    chk(v == 32'h8000_0102, "R7", "lock with fields", 64'(v), 64'h8000_0102);
    wr(8'h14, 32'h0000_0F01, 4'hF);
    rd(8'h14, v);
    chk(v == 32'h8000_0102, "R7", "locked ignores write", 64'(v), 64'h8000_0102);
    wr(8'h14, 32'h0, 4'b1000);
    rd(8'h17, v);
    chk(v == 32'h8000_0102, "R10", "lock not clearable", 64'(v), 64'h8000_0102);
    chk(v == 32'h8000_0102, "R2", "low address bits ignored", 64'(v), 64'h8000_0102);

    // Random traffic against the model
    rand_io = 1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_addr  = 8'($urandom());
      bus_we    = 1'($urandom());
      bus_be    = 4'($urandom());
      bus_wdata = $urandom() & (($urandom() % 16 == 0) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF);
    end
    @(negedge clk);
    bus_we = 0;
    rand_io = 0;

    // R10: reset releases the lock
    do_reset();
    rd(8'h14, v);
    chk(v == 0, "R10", "reset clears lock", 64'(v), 0);
    wr(8'h14, 32'h3, 4'hF);
    rd(8'h14, v);
    chk(v == 32'h3, "R10", "writable after reset", 64'(v), 64'h3);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule